// File: doc/BRIEF.md
# Pipelined Interval Timer with Coincident Force-Load Handling

This block is a 16-bit down-counting interval timer. Software fills a reload latch one byte at a time and writes a control byte holding a run bit, a port-pin enable, a one-shot select, a force-load strobe and a count-source select. The run request reaches the counter through a short pipeline of flip-flops. When the counter hits zero on an enabled cycle it reloads from the latch. At the same time it raises a one-cycle underflow pulse, optionally drives that pulse onto a pin, and sets an interrupt flag. The interrupt output is that flag gated by a mask bit.

The design rests on one point: the count pipeline is flushed only by the timer's own underflow. A force-load passes through one extra flip-flop and only reloads the counter. A latch write only updates the latch. So an underflow on the cycle right after a force-load still produces its pulse and its interrupt, and counting after any load stays cycle-exact.

Top module: `ivt_timer`

## Requirements
- R1: After reset the counter reads 16'hFFFF, and unf_pulse, pin_out and irq are low.
- R2: With the clock as count source (control bit 4 = 0), the counter decrements once per cycle. The first decrement comes on the third edge after the edge that writes run (control bit 0 = 1). An enabled cycle with the counter at zero is an underflow: the counter reloads from the latch and the pipeline empties. The next underflow therefore follows L+3 cycles later for latch value L.
- R3: Each underflow gives a unf_pulse exactly one cycle wide, registered on the underflow edge. pin_out copies the pulse only when control bit 1 is set.
- R4: With control bit 2 set (one-shot), an underflow clears the run bit, and the counter then holds the latch value.
- R5: Writing control with bit 3 set loads the counter from the latch on the edge after the write edge. A decrement due on the write edge itself still happens.
- R6: A force-load does not flush the pipeline: a running counter decrements on the edge after the load. Bit 3 is a strobe that loads exactly once.
- R7: An underflow on the edge right after a force-load write still yields unf_pulse, pin_out and the interrupt flag, with the counter at the latch value.
- R8: Writing the high byte while run is 0 loads the counter with {new high byte, latch low byte} on that edge, and any decrements still draining from the pipeline still apply. While running, byte writes change only the latch.
- R9: An underflow sets the interrupt flag. irq is the flag ANDed with the mask (wr_mask stores din[0]). A rd_stat cycle clears the flag unless an underflow occurs on the same edge.
- R10: With control bit 4 set, only ext_tick cycles feed the pipeline. An ext_tick high on one edge decrements the counter two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_lo | input | 1 | Write strobe, latch low byte |
| wr_hi | input | 1 | Write strobe, latch high byte |
| wr_ctl | input | 1 | Write strobe, control byte |
| wr_mask | input | 1 | Write strobe, interrupt mask (din[0]) |
| rd_stat | input | 1 | Status read strobe, clears the flag |
| din | input | 8 | Write data byte |
| ext_tick | input | 1 | External count pulse |
| cnt | output | 16 | Current counter value |
| unf_pulse | output | 1 | One-cycle underflow pulse |
| pin_out | output | 1 | Underflow pulse gated to the port pin |
| irq | output | 1 | Interrupt request |

## Verification
The key case times a force-load write so that the counter steps from one to zero on the write edge. If a design flushed the pipeline on force-load, or loaded without the delay flop, the underflow, its pulse and its interrupt would be lost on the next edge. Other cases count the decrement just after a force-load and the drain decrement after a stopped high-byte write. A design that cleared the pipeline on those loads would come out one count high. The bench also measures first-underflow latency and period over several latch values, including zero, and checks that one-shot mode stops after its single pulse. A pipeline whose depth differs between clock and external sources would show its decrement on the wrong edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Control byte field positions
    localparam int CTL_RUN = 0;
    localparam int CTL_PIN = 1;
    localparam int CTL_ONE = 2;
    localparam int CTL_FLD = 3;
    localparam int CTL_EXT = 4;
    localparam int CTL_W   = 5;

    typedef struct packed {
        logic ext_src;
        logic one_shot;
        logic pin_en;
        logic run;
    } ivt_ctl_t;

    typedef enum logic [1:0] {
        LD_NONE  = 2'd0,
        LD_FORCE = 2'd1,
        LD_HIGH  = 2'd2
    } ivt_ld_e;

    function automatic ivt_ctl_t ctl_decode(input logic [CTL_W-1:0] b);
        ivt_ctl_t c;
        c.run      = b[CTL_RUN];
        c.pin_en   = b[CTL_PIN];
        c.one_shot = b[CTL_ONE];
        c.ext_src  = b[CTL_EXT];
        return c;
    endfunction

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  wr_ctl,
    input  logic [DATA_W-1:0]     din,
    input  logic                  unf_i,
    output ivt_ctl_t              ctl_o,
    output logic [2*DATA_W-1:0]   latch_o,
    output logic                  load_o,
    output logic [2*DATA_W-1:0]   load_val_o
);
    localparam int LAT_W = 2 * DATA_W;

    logic [DATA_W-1:0] lat_lo_q, lat_hi_q;
    ivt_ctl_t          ctl_q;
    logic              fld_q;      // load flip-flop: delays force-load by one cycle
    ivt_ld_e           ld_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo_q <= '1;
            lat_hi_q <= '1;
            ctl_q    <= '0;
            fld_q    <= 1'b0;
        end else begin
            if (wr_lo) lat_lo_q <= din;
            if (wr_hi) lat_hi_q <= din;
            fld_q <= wr_ctl & din[CTL_FLD];
            if (wr_ctl)
                ctl_q <= ctl_decode(din[CTL_W-1:0]);
            else if (unf_i && ctl_q.one_shot)
                ctl_q.run <= 1'b0;
        end
    end

    always_comb begin
        if (fld_q)                   ld_src = LD_FORCE;
        else if (wr_hi && !ctl_q.run) ld_src = LD_HIGH;
        else                         ld_src = LD_NONE;
    end

    assign ctl_o      = ctl_q;
    assign latch_o    = {lat_hi_q, lat_lo_q};
    assign load_o     = (ld_src != LD_NONE);
    assign load_val_o = {wr_hi ? din : lat_hi_q, wr_lo ? din : lat_lo_q};

    // R4
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (unf_i && ctl_q.one_shot && !wr_ctl) |=> !ctl_q.run);

    // R5
    fld_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && din[CTL_FLD]) |=> load_o);

    // R6
    fld_once_chk: assert property (@(posedge clk) disable iff (rst)
        (fld_q && !wr_ctl && !wr_hi) |=> !load_o);

    logic unused_lat_w;
    assign unused_lat_w = (LAT_W == 0);

endmodule

// File: rtl/ivt_pipe.sv
module ivt_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    input  logic unf_i,
    output logic en_o
);
    logic [DEPTH-1:0] st_q;

    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst || unf_i) st_q <= '0;
                else              st_q <= run_i & tick_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst || unf_i) st_q <= '0;
                else              st_q <= {st_q[DEPTH-2:0], run_i & tick_i};
            end
        end
    endgenerate

    assign en_o = st_q[DEPTH-1];

    // Only an underflow may break the advance of a stage
    for (genvar i = 1; i < DEPTH; i++) begin : g_adv
        // R6
        stage_adv_chk: assert property (@(posedge clk) disable iff (rst)
            (st_q[i-1] && !unf_i) |=> st_q[i]);
    end

    // R2
    unf_flush_chk: assert property (@(posedge clk) disable iff (rst)
        unf_i |=> !en_o);

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] latch_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             unf_o,
    output logic             pulse_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;

    assign unf_o = en_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '1;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= unf_o;
            if (load_i)      cnt_q <= load_val_i;
            else if (unf_o)  cnt_q <= latch_i;
            else if (en_i)   cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o   = cnt_q;
    assign pulse_o = pulse_q;

    // R3
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);

    // R5
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == $past(load_val_i));

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (unf_o && !load_i) |=> cnt_q == $past(latch_i));

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PIPE_DEPTH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  wr_ctl,
    input  logic                  wr_mask,
    input  logic                  rd_stat,
    input  logic [DATA_W-1:0]     din,
    input  logic                  ext_tick,
    output logic [2*DATA_W-1:0]   cnt,
    output logic                  unf_pulse,
    output logic                  pin_out,
    output logic                  irq
);
    localparam int CNT_W = 2 * DATA_W;

    ivt_ctl_t         ctl;
    logic [CNT_W-1:0] latch, load_val;
    logic             load, unf, en, tick;
    logic             flag_q, mask_q;

    ivt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl),
        .din(din), .unf_i(unf), .ctl_o(ctl), .latch_o(latch),
        .load_o(load), .load_val_o(load_val)
    );

    assign tick = ctl.ext_src ? ext_tick : 1'b1;

    ivt_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk(clk), .rst(rst), .run_i(ctl.run), .tick_i(tick),
        .unf_i(unf), .en_o(en)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .en_i(en), .load_i(load), .load_val_i(load_val),
        .latch_i(latch), .cnt_o(cnt), .unf_o(unf), .pulse_o(unf_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (unf)          flag_q <= 1'b1;
            else if (rd_stat) flag_q <= 1'b0;
            if (wr_mask)      mask_q <= din[0];
        end
    end

    assign irq     = flag_q & mask_q;
    assign pin_out = unf_pulse & ctl.pin_en;

    // R9
    flag_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        unf_pulse |-> flag_q);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !unf) |=> !irq);

endmodule

// File: tb/ivt_timer_tb.sv
module ivt_timer_tb;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [15:0] lat;
        int          first;
        int          period;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{16'd0,  3,  3},
        '{16'd1,  4,  4},
        '{16'd5,  8,  8},
        '{16'd12, 15, 15}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_lo = 0, wr_hi = 0, wr_ctl = 0, wr_mask = 0, rd_stat = 0;
    logic [7:0]  din = '0;
    logic        ext_tick = 1'b0;
    logic [15:0] cnt;
    logic        unf_pulse, pin_out, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_P/2) clk = ~clk;

    ivt_timer u_dut (
        .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl),
        .wr_mask(wr_mask), .rd_stat(rd_stat), .din(din), .ext_tick(ext_tick),
        .cnt(cnt), .unf_pulse(unf_pulse), .pin_out(pin_out), .irq(irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // kind: 0 lo, 1 hi, 2 ctl, 3 mask, 4 status read
    task automatic wr(input int kind, input logic [7:0] v);
        din = v;
        case (kind)
            0: wr_lo   = 1'b1;
            1: wr_hi   = 1'b1;
            2: wr_ctl  = 1'b1;
            3: wr_mask = 1'b1;
            default: rd_stat = 1'b1;
        endcase
        step();
        wr_lo = 0; wr_hi = 0; wr_ctl = 0; wr_mask = 0; rd_stat = 0;
    endtask

    task automatic wait_unf(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!unf_pulse && n < 1000);
    endtask

    task automatic stop_and_drain();
        wr(2, 8'h00);
        repeat (3) step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL all requirements: watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, pulses;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        chk("R1", "cnt", cnt, 32'hFFFF);
        chk("R1", "unf_pulse", unf_pulse, 0);
        chk("R1", "pin_out", pin_out, 0);
        chk("R1", "irq", irq, 0);

        // Table walk: continuous mode with pin enabled, several latch values
        foreach (VEC[i]) begin
            stop_and_drain();
            wr(0, VEC[i].lat[7:0]);
            wr(1, VEC[i].lat[15:8]);
            chk("R8", "stopped high write loads", cnt, VEC[i].lat);
            wr(2, 8'h03);
            wait_unf(n);
            chk("R2", "first underflow latency", n, VEC[i].first);
            chk("R3", "pin_out with pin enabled", pin_out, 1);
            chk("R2", "reload value", cnt, VEC[i].lat);
            if (i == 0) chk("R9", "irq masked off", irq, 0);
            step();
            chk("R3", "pulse one cycle wide", unf_pulse, 0);
            wait_unf(n);
            chk("R2", "underflow period", n + 1, VEC[i].period);
        end

        // R9 mask and clear, R3 pin disabled
        stop_and_drain();
        wr(4, 8'h00);
        wr(3, 8'h01);
        chk("R9", "irq after clear", irq, 0);
        wr(0, 8'd2);
        wr(1, 8'd0);
        wr(2, 8'h01);
        wait_unf(n);
        chk("R3", "pin_out with pin disabled", pin_out, 0);
        chk("R9", "irq on underflow", irq, 1);
        step();
        wr(4, 8'h00);
        chk("R9", "irq cleared by status read", irq, 0);

        // R4 one-shot
        stop_and_drain();
        wr(0, 8'd3);
        wr(1, 8'd0);
        wr(2, 8'h05);
        wait_unf(n);
        chk("R4", "one-shot first underflow", n, 6);
        pulses = 0;
        for (int k = 0; k < 10; k++) begin
            step();
            if (unf_pulse) pulses++;
        end
        chk("R4", "no pulse after one-shot", pulses, 0);
        chk("R4", "counter holds latch", cnt, 3);

        // R5 / R6 / R8 force-load away from underflow
        wr(4, 8'h00);
        wr(0, 8'd100);
        wr(1, 8'd0);
        chk("R8", "stopped load", cnt, 100);
        wr(2, 8'h01);
        repeat (10) step();
        chk("R2", "running count", cnt, 92);
        wr(0, 8'd50);
        chk("R8", "low write while running", cnt, 91);
        wr(1, 8'd0);
        chk("R8", "high write while running", cnt, 90);
        wr(2, 8'h09);
        chk("R5", "decrement on write edge", cnt, 89);
        step();
        chk("R5", "load one cycle late", cnt, 50);
        step();
        chk("R6", "no flush after force-load", cnt, 49);
        step();
        chk("R6", "strobe loads once", cnt, 48);

        // R7 force-load coinciding with underflow
        n = 0;
        while (cnt != 16'd1 && n < 200) begin
            step();
            n++;
        end
        wr(2, 8'h0B);
        chk("R7", "cnt at force-load edge", cnt, 0);
        chk("R7", "no early pulse", unf_pulse, 0);
        chk("R7", "no early irq", irq, 0);
        step();
        chk("R7", "pulse kept", unf_pulse, 1);
        chk("R7", "pin kept", pin_out, 1);
        chk("R7", "irq kept", irq, 1);
        chk("R7", "reloaded", cnt, 50);
        step();
        chk("R7", "pulse ends", unf_pulse, 0);
        chk("R2", "refill 1", cnt, 50);
        step();
        chk("R2", "refill 2", cnt, 50);
        step();
        chk("R2", "count resumes", cnt, 49);

        // R8 stopped high write does not flush
        wr(2, 8'h00);
        chk("R8", "decrement on stop edge", cnt, 48);
        wr(1, 8'd0);
        chk("R8", "stopped high write load", cnt, 50);
        step();
        chk("R8", "drain decrement kept", cnt, 49);
        step();
        chk("R8", "pipeline drained", cnt, 49);

        // R10 external source
        wr(2, 8'h11);
        repeat (5) step();
        chk("R10", "idle without ext tick", cnt, 49);
        ext_tick = 1'b1;
        step();
        ext_tick = 1'b0;
        chk("R10", "tick edge", cnt, 49);
        step();
        chk("R10", "tick + 1", cnt, 49);
        step();
        chk("R10", "tick + 2 decrement", cnt, 48);
        repeat (3) step();
        chk("R10", "single decrement", cnt, 48);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule